// File: doc/BRIEF.md
# GPIO Port Pair with Serial Sensor Glue

This block holds the registers of two general-purpose I/O ports, called A and D, on a word-addressed register bus. Each port has three registers: the value to drive, an enable mask for the drivers, and a read-only input view. Reading a port's input view returns the driven value masked by its enable, with external status pins ORed on top. On port A, the ready line of a NAND flash appears at input bit 7. On port D, the serial output of a bit-banged temperature sensor appears at input bit 4.

Software bit-bangs the sensor through port D's drive register. Bit 1 of that register is the serial clock and bit 4 is the serial data. Whenever a write to that register changes bit 1, the block sends the sensor model a one-cycle edge strobe. The strobe carries the new clock level and the new data bit. The register window holds 23 words. Offsets that are not assigned to a port act as plain read/write storage.

Reads return data one cycle after the request, flagged by a valid pulse.

Top module: `gpio_sensor_glue`

## Requirements
- R1: After reset, all 23 storage words are zero, and so are the port drive and enable outputs. The strobe, read-valid, strobe level and strobe data outputs are low.
- R2: A read at offset 0x00, 0x02, 0x10 or 0x12 returns the last value written there. The data appears on `bus_rdata` in the cycle after the request, together with a one-cycle `bus_rvalid` pulse. `bus_rdata` holds its value between reads.
- R3: A read at offset 0x01 returns (word 0x00 AND word 0x02) OR (`nand_ready` in bit 7). `nand_ready` is sampled in the request cycle.
- R4: A read at offset 0x11 returns (word 0x10 AND word 0x12) OR (`sensor_sdo` in bit 4). `sensor_sdo` is sampled in the request cycle.
- R5: Suppose a write to offset 0x10 carries a bit 1 that differs from the stored bit 1. Then `sclk_strobe` is high for exactly the next cycle. In that cycle `sclk_level` equals the written bit 1 and `sdata_bit` equals the written bit 4. Both hold their values until the next strobe.
- R6: No strobe follows a write to offset 0x10 that leaves bit 1 unchanged. No strobe follows a write to any other offset.
- R7: Offsets 0x03–0x0F, 0x13–0x16, 0x01 and 0x11 accept writes as plain storage. Offsets 0x03–0x0F and 0x13–0x16 read back the value written. A write to 0x01 or 0x11 has no effect on what those offsets read back.
- R8: At offsets 23–31, writes change nothing and reads return zero.
- R9: A read issued in the same cycle as a write returns the contents from before the write.
- R10: `porta_out`, `porta_oe`, `portd_out` and `portd_oe` show words 0x00, 0x02, 0x10 and 0x12. Each output changes in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after request |
| bus_rvalid | output | 1 | Read data valid pulse |
| nand_ready | input | 1 | Flash ready status pin |
| sensor_sdo | input | 1 | Sensor serial output |
| porta_out | output | 32 | Port A drive value |
| porta_oe | output | 32 | Port A driver enables |
| portd_out | output | 32 | Port D drive value |
| portd_oe | output | 32 | Port D driver enables |
| sclk_strobe | output | 1 | One-cycle serial clock edge event |
| sclk_level | output | 1 | Clock level of the last edge event |
| sdata_bit | output | 1 | Data bit of the last edge event |

## Verification
A wrong stored bit in port D's drive word does not stay hidden. The next write decides whether to strobe by comparing against that stored bit, so the edge events go missing or double up one cycle after that write. The fault also shows at once on `portd_out`. Corruption in the enable words or in the input-view mux shows up on the very next read of a data-in offset. The bench toggles the status pins across those reads so that the AND and OR terms are separated.

// File: rtl/gpio_sensor_glue.sv
module gpio_sensor_glue #(
  parameter int DW        = 32,
  parameter int AW        = 5,
  parameter int NWORDS    = 23,
  parameter int PA_OUT    = 'h00,
  parameter int PA_IN     = 'h01,
  parameter int PA_OE     = 'h02,
  parameter int PD_OUT    = 'h10,
  parameter int PD_IN     = 'h11,
  parameter int PD_OE     = 'h12,
  parameter int SCLK_BIT  = 1,
  parameter int SDAT_BIT  = 4,
  parameter int READY_POS = 7,
  parameter int SDO_POS   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic          nand_ready,
  input  logic          sensor_sdo,
  output logic [DW-1:0] porta_out,
  output logic [DW-1:0] porta_oe,
  output logic [DW-1:0] portd_out,
  output logic [DW-1:0] portd_oe,
  output logic          sclk_strobe,
  output logic          sclk_level,
  output logic          sdata_bit
);

  localparam logic [AW-1:0] A_PA_IN  = AW'(PA_IN);
  localparam logic [AW-1:0] A_PD_IN  = AW'(PD_IN);
  localparam logic [AW-1:0] A_PD_OUT = AW'(PD_OUT);
  localparam logic [AW-1:0] A_LIMIT  = AW'(NWORDS);

  logic [DW-1:0] regs [NWORDS];
  logic [DW-1:0] pa_in, pd_in, rd_mux;
  logic          in_range, pd_hit, toggle;

  assign in_range  = bus_addr < A_LIMIT;
  assign porta_out = regs[PA_OUT];
  assign porta_oe  = regs[PA_OE];
  assign portd_out = regs[PD_OUT];
  assign portd_oe  = regs[PD_OE];

  assign pa_in = (regs[PA_OUT] & regs[PA_OE]) | (DW'(nand_ready) << READY_POS);
  assign pd_in = (regs[PD_OUT] & regs[PD_OE]) | (DW'(sensor_sdo) << SDO_POS);

  always_comb begin
    if (!in_range)               rd_mux = '0;
    else if (bus_addr == A_PA_IN) rd_mux = pa_in;
    else if (bus_addr == A_PD_IN) rd_mux = pd_in;
    else                         rd_mux = regs[bus_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) regs[i] <= '0;
    end else if (bus_wr && in_range) begin
      regs[bus_addr] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign pd_hit = bus_wr && bus_addr == A_PD_OUT;
  assign toggle = pd_hit && (bus_wdata[SCLK_BIT] != regs[PD_OUT][SCLK_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_strobe <= 1'b0;
      sclk_level  <= 1'b0;
      sdata_bit   <= 1'b0;
    end else begin
      sclk_strobe <= toggle;
      if (toggle) begin
        sclk_level <= bus_wdata[SCLK_BIT];
        sdata_bit  <= bus_wdata[SDAT_BIT];
      end
    end
  end

  // R5
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_strobe |-> $past(bus_wr) && $past(bus_addr) == A_PD_OUT);

  // R5
  strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_strobe |-> sclk_level == portd_out[SCLK_BIT]);

  // R6
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PD_OUT && bus_wdata[SCLK_BIT] == portd_out[SCLK_BIT])
      |=> !sclk_strobe);

  // R2
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R2
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid && $stable(bus_rdata));

  // R8
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_range) |=> bus_rdata == '0);

  // R8
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !in_range) |=> $stable(porta_out) && $stable(portd_out)
      && $stable(porta_oe) && $stable(portd_oe));

endmodule

// File: tb/test_gpio_sensor_glue.sv
`timescale 1ns/1ps
module test_gpio_sensor_glue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        nand_ready = 1'b0, sensor_sdo = 1'b0;
  logic [31:0] porta_out, porta_oe, portd_out, portd_oe;
  logic        sclk_strobe, sclk_level, sdata_bit;

  always #2.5 clk = ~clk;

  gpio_sensor_glue i_gpio_sensor_glue (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .nand_ready(nand_ready), .sensor_sdo(sensor_sdo),
    .porta_out(porta_out), .porta_oe(porta_oe), .portd_out(portd_out),
    .portd_oe(portd_oe), .sclk_strobe(sclk_strobe), .sclk_level(sclk_level),
    .sdata_bit(sdata_bit));

  int checks = 0, errors = 0;
  logic [31:0] m [32];
  logic [31:0] e_rdata = 0;
  logic e_rvalid = 0, e_strobe = 0, e_level = 0, e_data = 0;
  string rtag = "R2";

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(int a);
    if (a >= 23) return 0;
    if (a == 1)  return (m[0] & m[2]) | (32'(nand_ready) << 7);
    if (a == 17) return (m[16] & m[18]) | (32'(sensor_sdo) << 4);
    return m[a];
  endfunction

  function automatic string tag_of(int a, bit wr_same);
    if (wr_same) return "R9";
    if (a >= 23) return "R8";
    if (a == 1)  return "R3";
    if (a == 17) return "R4";
    if (a == 0 || a == 2 || a == 16 || a == 18) return "R2";
    return "R7";
  endfunction

  task automatic cyc(bit wr, bit rd, int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = 5'(a); bus_wdata = d;
    @(posedge clk);
    e_rvalid = rd;
    if (rd) begin
      e_rdata = model_read(a);
      rtag = tag_of(a, wr && a < 23);
    end
    e_strobe = wr && a == 16 && d[1] != m[16][1];
    if (e_strobe) begin e_level = d[1]; e_data = d[4]; end
    if (wr && a < 23) m[a] = d;
    #1;
    chk("R2", 32'(bus_rvalid), 32'(e_rvalid));
    chk(rtag, bus_rdata, e_rdata);
    chk(e_strobe ? "R5" : "R6", 32'(sclk_strobe), 32'(e_strobe));
    chk("R5", 32'(sclk_level), 32'(e_level));
    chk("R5", 32'(sdata_bit), 32'(e_data));
    chk("R10", porta_out, m[0]);
    chk("R10", porta_oe, m[2]);
    chk("R10", portd_out, m[16]);
    chk("R10", portd_oe, m[18]);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk("R1", {bus_rdata}, 0);
    chk("R1", 32'(bus_rvalid), 0);
    chk("R1", 32'(sclk_strobe), 0);
    chk("R1", 32'(sclk_level), 0);
    chk("R1", 32'(sdata_bit), 0);
    chk("R1", porta_out | porta_oe | portd_out | portd_oe, 0);
    for (int a = 0; a < 23; a++) cyc(0, 1, a, 0);
    // R2 / R3 port A
    cyc(1, 0, 0, 32'hA5A5_00FF);
    cyc(1, 0, 2, 32'h0F0F_0F0F);
    cyc(0, 1, 0, 0);
    cyc(0, 1, 2, 0);
    nand_ready = 0; cyc(0, 1, 1, 0);
    nand_ready = 1; cyc(0, 1, 1, 0);
    // R7 data-in writes do not affect readback
    cyc(1, 0, 1, 32'hFFFF_FFFF);
    nand_ready = 0; cyc(0, 1, 1, 0);
    // R4 port D readback
    cyc(1, 0, 18, 32'hFFFF_FFEF);
    cyc(1, 0, 16, 32'h0000_0013);
    sensor_sdo = 0; cyc(0, 1, 17, 0);
    sensor_sdo = 1; cyc(0, 1, 17, 0);
    cyc(1, 0, 17, 32'h1234_5678);
    sensor_sdo = 0; cyc(0, 1, 17, 0);
    // R5 / R6 clock edges
    cyc(1, 0, 16, 32'h0000_0011);
    cyc(1, 0, 16, 32'h0000_0001);
    cyc(1, 0, 16, 32'h0000_0012);
    cyc(1, 0, 16, 32'h0000_0010);
    cyc(1, 0, 16, 32'h0000_0002);
    cyc(1, 0, 16, 32'h0000_0012);
    cyc(1, 0, 18, 32'h0000_0000);
    cyc(1, 0, 0, 32'h0000_0002);
    cyc(0, 0, 0, 0);
    // R7 plain storage
    cyc(1, 0, 5, 32'hDEAD_BEEF);
    cyc(1, 0, 22, 32'hCAFE_0001);
    cyc(0, 1, 5, 0);
    cyc(0, 1, 22, 0);
    // R8 out of range
    cyc(1, 0, 23, 32'hFFFF_FFFF);
    cyc(1, 0, 31, 32'h5555_5555);
    cyc(0, 1, 23, 0);
    cyc(0, 1, 31, 0);
    // R9 read during write
    cyc(1, 1, 5, 32'h0BAD_F00D);
    cyc(0, 1, 5, 0);
    cyc(1, 1, 16, 32'h0000_0000);
    for (int n = 0; n < 400; n++) begin
      int a;
      a = ($urandom % 4 == 0) ? int'($urandom % 32)
          : ((($urandom % 2) == 0) ? int'($urandom % 3) : 16 + int'($urandom % 3));
      nand_ready = 1'($urandom);
      sensor_sdo = 1'($urandom);
      cyc(1'($urandom), 1'($urandom), a, $urandom);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule